// File: doc/BRIEF.md
# Dual-Lane Serial ADC Readout Controller

This block is the host side of an eight-channel, 18-bit simultaneous-sampling converter whose results leave over a serial link on two data lanes at once. After the block's own reset it sends the converter a reset pulse. When `go_i` is high and the converter reports not-busy, it raises the shared conversion-start output. It then follows the busy input through its high phase and waits a programmable settling time after busy falls. Next it lowers chip select and runs a divided serial clock for one full frame.

Lane 0 carries channels 0 to 3 and lane 1 carries channels 4 to 7, one channel after another, each MSB first. The lowering of chip select presents each lane's MSB. The converter launches every later bit on a serial-clock rising edge, and the block samples on the serial-clock falling edge. The first-data input is checked at two points: at the first sample of a frame and at the first sample of the second word. A frame that fails either check is dropped and sets a sticky error flag.

A frame that passes is offered as eight results on a valid/ready stream in channel order. Back-pressure on this stream holds the current result steady. No new conversion starts until all eight results have been accepted.

Top module: `adc_lane_reader`

## Requirements
- R1: While `rst_n` is low, and for exactly RST_CYC clock cycles after it rises, `rst_adc_o` is high. During that time `cnvst_o` stays low and `cs_n_o` stays high.
- R2: `cnvst_o` rises only from idle, with `go_i` high and `busy_i` sampled low. It stays high for CNV_CYC cycles. While busy is high, or while a frame is being read or drained, `go_i` starts nothing: exactly one start occurs per frame.
- R3: `cs_n_o` falls on the (SETTLE_CYC+1)-th rising clock edge after `busy_i` goes low. This counts the edge that first samples busy low.
- R4: `sclk_o` idles high whenever `cs_n_o` is high. Its first falling edge comes SCLK_DIV cycles after `cs_n_o` falls, and each later falling edge follows the previous one by 2*SCLK_DIV cycles. A frame has exactly 4*18 = 72 falling edges. `cs_n_o` rises SCLK_DIV cycles after the last fall, together with `sclk_o` returning high.
- R5: Each lane is sampled on the clock edge that drives `sclk_o` low, and bits are assembled MSB first. Bits 0..17 of lane 0 form channel 0, bits 18..35 form channel 1, and so on. Lane 1 supplies channels 4..7 in the same way.
- R6: `first_i` must be sampled high at the first fall of a frame and low at the 19th fall. If either check fails, the frame produces no results and `align_err_o` goes high.
- R7: Results leave in channel order 0..7. `res_chan_o` carries the 3-bit channel index, and `res_data_o` carries the 18-bit two's-complement word exactly as received.
- R8: `res_valid_o` stays high, with `res_data_o` and `res_chan_o` stable, until `res_ready_i` is high at a clock edge. Each handshake moves on by one channel. `res_valid_o` is never high while chip select is low.
- R9: `align_err_o` is cleared only by `rst_n`. Later good frames still produce results while it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Request conversions while high |
| busy_i | input | 1 | Converter busy indication |
| first_i | input | 1 | Converter first-channel flag |
| lane_i | input | N_LANES | Serial data lanes, bit 0 = channels 0..3 |
| rst_adc_o | output | 1 | Converter reset pulse |
| cnvst_o | output | 1 | Shared conversion start |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idle high |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Result accepted by sink |
| res_data_o | output | DATA_W | Result word, two's complement |
| res_chan_o | output | CH_W | Channel index of the result |
| align_err_o | output | 1 | Sticky frame-alignment error |

## Verification
The converter model in the bench raises and lowers busy half a cycle clear of the clock. The bench then counts rising edges until chip select is seen low, expecting SETTLE_CYC+1. Serial-clock and chip-select edges are stamped with a cycle counter. This lets the bench check that the first fall lands SCLK_DIV cycles after chip select falls, that the last fall lands 71 full periods later, and that chip select rises SCLK_DIV cycles after that. Results are compared at the falling clock edge that precedes the handshake edge, because data and ready are stable there. While the sink withholds ready, the bench also checks that the offered word is held unchanged on every cycle.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [3:0] {
    ST_RST, ST_IDLE, ST_CNV, ST_WBH, ST_WBL,
    ST_SETTLE, ST_XFER, ST_DONE, ST_DRAIN
  } seq_state_t;
endpackage

// File: rtl/sclk_gen.sv
module sclk_gen #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sclk,
  output logic fall_stb,
  output logic rise_stb
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap     = en && (cnt == CNT_W'(DIV - 1));
  assign fall_stb = wrap && sclk;
  assign rise_stb = wrap && !sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b1;
    end else if (!en) begin
      cnt  <= '0;
      sclk <= 1'b1;
    end else if (wrap) begin
      cnt  <= '0;
      sclk <= !sclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lane_capture.sv
module lane_capture #(
  parameter int W     = 18,
  parameter int WORDS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        smp,
  input  logic                        din,
  input  logic                        word_end,
  input  logic [$clog2(WORDS)-1:0]    widx,
  output logic [WORDS-1:0][W-1:0]     words
);
  logic [W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '0;
      words <= '0;
    end else if (smp) begin
      sh <= {sh[W-2:0], din};
      if (word_end) words[widx] <= {sh[W-2:0], din};
    end
  end
endmodule

// File: rtl/readout_seq.sv
module readout_seq
  import adc_rd_pkg::*;
#(
  parameter int W          = 18,
  parameter int WORDS      = 4,
  parameter int RST_CYC    = 25,
  parameter int CNV_CYC    = 2,
  parameter int SETTLE_CYC = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     go,
  input  logic                     busy_i,
  input  logic                     first_i,
  input  logic                     fall_stb,
  input  logic                     rise_stb,
  input  logic                     out_busy,
  output logic                     rst_adc,
  output logic                     cnvst,
  output logic                     cs_n,
  output logic                     xfer_en,
  output logic                     smp,
  output logic                     word_end,
  output logic [$clog2(WORDS)-1:0] widx,
  output logic                     load,
  output logic                     align_err
);
  localparam int MAX_A = (RST_CYC > CNV_CYC) ? RST_CYC : CNV_CYC;
  localparam int MAX_C = (MAX_A > SETTLE_CYC) ? MAX_A : SETTLE_CYC;
  localparam int TMR_W = $clog2(MAX_C + 1);
  localparam int BC_W  = $clog2(W);
  localparam int WC_W  = $clog2(WORDS + 1);
  localparam int WI_W  = $clog2(WORDS);

  seq_state_t        state;
  logic [TMR_W-1:0]  tmr;
  logic [BC_W-1:0]   bcnt;
  logic [WC_W-1:0]   wcnt;
  logic              bad;

  assign rst_adc  = (state == ST_RST);
  assign cnvst    = (state == ST_CNV);
  assign xfer_en  = (state == ST_XFER);
  assign cs_n     = !xfer_en;
  assign smp      = xfer_en && fall_stb && (wcnt < WC_W'(WORDS));
  assign word_end = smp && (bcnt == BC_W'(W - 1));
  assign widx     = wcnt[WI_W-1:0];
  assign load     = (state == ST_DONE) && !bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RST;
      tmr       <= '0;
      bcnt      <= '0;
      wcnt      <= '0;
      bad       <= 1'b0;
      align_err <= 1'b0;
    end else begin
      case (state)
        ST_RST: begin
          if (tmr == TMR_W'(RST_CYC - 1)) begin
            state <= ST_IDLE;
            tmr   <= '0;
          end else tmr <= tmr + 1'b1;
        end
        ST_IDLE: begin
          if (go && !busy_i) begin
            state <= ST_CNV;
            tmr   <= '0;
          end
        end
        ST_CNV: begin
          if (tmr == TMR_W'(CNV_CYC - 1)) begin
            state <= ST_WBH;
            tmr   <= '0;
          end else tmr <= tmr + 1'b1;
        end
        ST_WBH: if (busy_i) state <= ST_WBL;
        ST_WBL: begin
          if (!busy_i) begin
            state <= ST_SETTLE;
            tmr   <= '0;
          end
        end
        ST_SETTLE: begin
          if (tmr == TMR_W'(SETTLE_CYC - 1)) begin
            state <= ST_XFER;
            tmr   <= '0;
            bcnt  <= '0;
            wcnt  <= '0;
            bad   <= 1'b0;
          end else tmr <= tmr + 1'b1;
        end
        ST_XFER: begin
          if (smp) begin
            if (bcnt == '0 && wcnt == WC_W'(0) && !first_i) bad <= 1'b1;
            if (bcnt == '0 && wcnt == WC_W'(1) && first_i)  bad <= 1'b1;
            if (bcnt == BC_W'(W - 1)) begin
              bcnt <= '0;
              wcnt <= wcnt + 1'b1;
            end else bcnt <= bcnt + 1'b1;
          end
          if (rise_stb && wcnt == WC_W'(WORDS)) state <= ST_DONE;
        end
        ST_DONE: begin
          align_err <= align_err | bad;
          state     <= bad ? ST_IDLE : ST_DRAIN;
        end
        ST_DRAIN: if (!out_busy) state <= ST_IDLE;
        default: state <= ST_RST;
      endcase
    end
  end
endmodule

// File: rtl/res_out.sv
module res_out #(
  parameter int W = 18,
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [N-1:0][W-1:0]  words,
  input  logic                 ready,
  output logic                 valid,
  output logic [W-1:0]         data,
  output logic [$clog2(N)-1:0] chan
);
  localparam int CH_W = $clog2(N);

  assign data = words[chan];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      chan  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      chan  <= '0;
    end else if (valid && ready) begin
      if (chan == CH_W'(N - 1)) begin
        valid <= 1'b0;
        chan  <= '0;
      end else chan <= chan + 1'b1;
    end
  end
endmodule

// File: rtl/adc_lane_reader.sv
module adc_lane_reader #(
  parameter int DATA_W     = 18,
  parameter int LANE_WORDS = 4,
  parameter int N_LANES    = 2,
  parameter int SCLK_DIV   = 2,
  parameter int SETTLE_CYC = 3,
  parameter int RST_CYC    = 25,
  parameter int CNV_CYC    = 2,
  localparam int N_CH      = N_LANES * LANE_WORDS,
  localparam int CH_W      = $clog2(N_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              busy_i,
  input  logic              first_i,
  input  logic [N_LANES-1:0] lane_i,
  output logic              rst_adc_o,
  output logic              cnvst_o,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [DATA_W-1:0] res_data_o,
  output logic [CH_W-1:0]   res_chan_o,
  output logic              align_err_o
);
  localparam int WI_W = $clog2(LANE_WORDS);

  logic            xfer_en, fall_stb, rise_stb, smp, word_end, load;
  logic [WI_W-1:0] widx;
  logic [N_LANES-1:0][LANE_WORDS-1:0][DATA_W-1:0] lane_words;
  logic [N_CH-1:0][DATA_W-1:0] all_words;

  assign all_words = lane_words;

  readout_seq #(
    .W(DATA_W), .WORDS(LANE_WORDS), .RST_CYC(RST_CYC),
    .CNV_CYC(CNV_CYC), .SETTLE_CYC(SETTLE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go_i), .busy_i(busy_i), .first_i(first_i),
    .fall_stb(fall_stb), .rise_stb(rise_stb), .out_busy(res_valid_o),
    .rst_adc(rst_adc_o), .cnvst(cnvst_o), .cs_n(cs_n_o), .xfer_en(xfer_en),
    .smp(smp), .word_end(word_end), .widx(widx), .load(load),
    .align_err(align_err_o)
  );

  sclk_gen #(.DIV(SCLK_DIV)) u_sclk (
    .clk(clk), .rst_n(rst_n), .en(xfer_en),
    .sclk(sclk_o), .fall_stb(fall_stb), .rise_stb(rise_stb)
  );

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    lane_capture #(.W(DATA_W), .WORDS(LANE_WORDS)) u_cap (
      .clk(clk), .rst_n(rst_n), .smp(smp), .din(lane_i[l]),
      .word_end(word_end), .widx(widx), .words(lane_words[l])
    );
  end

  res_out #(.W(DATA_W), .N(N_CH)) u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .words(all_words),
    .ready(res_ready_i), .valid(res_valid_o), .data(res_data_o),
    .chan(res_chan_o)
  );
endmodule

// File: rtl/adc_lane_reader_chk.sv
module adc_lane_reader_chk #(
  parameter int DATA_W = 18,
  parameter int CH_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_i,
  input logic              rst_adc_o,
  input logic              cnvst_o,
  input logic              cs_n_o,
  input logic              sclk_o,
  input logic              res_valid_o,
  input logic              res_ready_i,
  input logic [DATA_W-1:0] res_data_o,
  input logic [CH_W-1:0]   res_chan_o,
  input logic              align_err_o
);
  assert_rst_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_adc_o |-> (cs_n_o && !cnvst_o));

  assert_start_not_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnvst_o) |-> !$past(busy_i));

  assert_no_start_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> !cnvst_o);

  assert_cs_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> !$past(busy_i));

  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);

  assert_valid_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |=>
      (res_valid_o && $stable(res_data_o) && $stable(res_chan_o)));

  assert_no_valid_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> !res_valid_o);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    align_err_o |=> align_err_o);
endmodule

bind adc_lane_reader adc_lane_reader_chk #(.DATA_W(DATA_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .rst_adc_o(rst_adc_o),
  .cnvst_o(cnvst_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
  .res_valid_o(res_valid_o), .res_ready_i(res_ready_i),
  .res_data_o(res_data_o), .res_chan_o(res_chan_o), .align_err_o(align_err_o)
);

// File: tb/tb_adc_lane_reader.sv
`timescale 1ns/1ps
module tb_adc_lane_reader;
  localparam int W = 18, NCH = 8, DIV = 2, SET = 3, RSTC = 25, BUSY_LEN = 30;

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0, busy = 1'b0, first = 1'b0, ready = 1'b0;
  logic [1:0] lane = '0;
  logic rst_adc_o, cnvst_o, cs_n_o, sclk_o, res_valid_o, align_err_o;
  logic [W-1:0] res_data_o;
  logic [2:0]   res_chan_o;

  always #2 clk = ~clk;

  adc_lane_reader #(.DATA_W(W), .LANE_WORDS(4), .N_LANES(2), .SCLK_DIV(DIV),
                    .SETTLE_CYC(SET), .RST_CYC(RSTC), .CNV_CYC(2)) dut (
    .clk(clk), .rst_n(rst_n), .go_i(go), .busy_i(busy), .first_i(first),
    .lane_i(lane), .rst_adc_o(rst_adc_o), .cnvst_o(cnvst_o), .cs_n_o(cs_n_o),
    .sclk_o(sclk_o), .res_valid_o(res_valid_o), .res_ready_i(ready),
    .res_data_o(res_data_o), .res_chan_o(res_chan_o), .align_err_o(align_err_o)
  );

  int errors = 0, checks = 0;
  logic [20:0] sb[$];
  logic [W-1:0] samp[NCH];
  int badmode = 0, cyc = 0, cnv_cnt = 0, fall_n = 0, bidx = 0;
  int t_csf = 0, t_f1 = 0, t_fl = 0, t_csr = 0;
  int ready_mode = 0;
  bit finished = 0, prev_stall = 0;
  logic [20:0] prev_item = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // converter model: lanes and first-data flag
  function automatic void drive_lanes();
    lane[0] = (bidx < 72) ? samp[bidx / 18][17 - (bidx % 18)] : 1'b0;
    lane[1] = (bidx < 72) ? samp[4 + bidx / 18][17 - (bidx % 18)] : 1'b0;
  endfunction

  always @(posedge clk) cyc++;
  always @(posedge cnvst_o) if (rst_n) cnv_cnt++;
  always @(negedge cs_n_o) if (rst_n) begin
    bidx = 0; fall_n = 0; drive_lanes(); first = (badmode != 1); t_csf = cyc;
  end
  always @(posedge cs_n_o) t_csr = cyc;
  always @(posedge sclk_o) if (rst_n && !cs_n_o) begin bidx++; drive_lanes(); end
  always @(negedge sclk_o) if (rst_n && !cs_n_o) begin
    fall_n++;
    if (fall_n == 1) t_f1 = cyc;
    t_fl = cyc;
    if (fall_n == 18) first = (badmode == 2);
  end

  // monitor / scoreboard
  always @(negedge clk) if (rst_n) begin
    logic [20:0] got, exp;
    got = {res_chan_o, res_data_o};
    if (prev_stall)
      check(res_valid_o && got == prev_item, "R8", "held while stalled", got, prev_item);
    ready = (ready_mode == 0) ? 1'b1 : (cyc % 3 == 0);
    if (res_valid_o && ready) begin
      if (sb.size() == 0) check(1'b0, "R6", "unexpected result", got, 0);
      else begin
        exp = sb.pop_front();
        check(got == exp, "R5 R7", "result {chan,data}", got, exp);
      end
    end
    prev_stall = res_valid_o && !ready;
    prev_item  = got;
  end

  task automatic conv(input int bm, input bit expect_out);
    int n0, n;
    badmode = bm;
    if (expect_out) for (int c = 0; c < NCH; c++) sb.push_back({3'(c), samp[c]});
    n0 = cnv_cnt;
    go = 1'b1;
    @(posedge cnvst_o);
    @(negedge clk); busy = 1'b1;
    repeat (BUSY_LEN) @(negedge clk);
    busy = 1'b0;
    n = 0;
    do begin @(posedge clk); #1; n++; end while (cs_n_o && n < 100);
    check(n == SET + 1, "R3", "edges from busy fall to cs low", n, SET + 1);
    go = 1'b0;
    @(posedge cs_n_o); #1;
    check(fall_n == 72, "R4", "falls per frame", fall_n, 72);
    check(t_f1 - t_csf == DIV, "R4", "cs fall to first sclk fall", t_f1 - t_csf, DIV);
    check(t_fl - t_f1 == 71 * 2 * DIV, "R4", "first to last fall", t_fl - t_f1, 71 * 2 * DIV);
    check(t_csr - t_fl == DIV, "R4", "last fall to cs rise", t_csr - t_fl, DIV);
    n = 0;
    while ((sb.size() != 0 || res_valid_o) && n < 2000) begin @(negedge clk); n++; end
    repeat (5) @(negedge clk);
    check(cnv_cnt == n0 + 1, "R2", "starts per frame", cnv_cnt - n0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R1 R4 watchdog expired: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(rst_adc_o == 1'b1, "R1", "converter reset during rst_n", rst_adc_o, 1);
    rst_n = 1'b1;
    n = 0;
    do begin @(posedge clk); #1; n++; end while (rst_adc_o && n < 100);
    check(n == RSTC, "R1", "reset pulse cycles after release", n, RSTC);
    check(cs_n_o == 1'b1 && cnvst_o == 1'b0, "R1", "cs high, start low", {cs_n_o, cnvst_o}, 2);
    check(res_valid_o == 1'b0, "R8", "no valid after reset", res_valid_o, 0);
    check(align_err_o == 1'b0, "R9", "error clear after reset", align_err_o, 0);

    // busy already high in idle: go must start nothing
    @(negedge clk); busy = 1'b1; go = 1'b1; n = cnv_cnt;
    repeat (20) @(negedge clk);
    check(cnv_cnt == n, "R2", "no start while busy", cnv_cnt - n, 0);
    go = 1'b0; busy = 1'b0;
    repeat (3) @(negedge clk);

    // frame A: extremes, sink always ready
    samp[0] = 18'h1FFFF; samp[1] = 18'h20000; samp[2] = 18'h3FFFF; samp[3] = 18'h00000;
    samp[4] = 18'h2AAAA; samp[5] = 18'h15555; samp[6] = 18'h00001; samp[7] = 18'h3FFFE;
    ready_mode = 0;
    conv(0, 1'b1);
    check(align_err_o == 1'b0, "R6", "good frame leaves no error", align_err_o, 0);

    // frame B: computed values, back-pressure
    for (int c = 0; c < NCH; c++) samp[c] = 18'((c + 1) * 18'h0A3C5 + 7);
    ready_mode = 1;
    conv(0, 1'b1);

    // misaligned at start
    conv(1, 1'b0);
    check(align_err_o == 1'b1, "R6", "flag low at first bit", align_err_o, 1);

    // good frame after error: results flow, flag stays
    for (int c = 0; c < NCH; c++) samp[c] = 18'(18'h3F00F - c * 18'h01234);
    ready_mode = 0;
    conv(0, 1'b1);
    check(align_err_o == 1'b1, "R9", "error sticky over good frame", align_err_o, 1);

    // misaligned at word boundary
    conv(2, 1'b0);
    check(align_err_o == 1'b1, "R6", "flag high at 19th bit", align_err_o, 1);
    check(sb.size() == 0, "R7", "all expected results seen", sb.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule